// File: doc/BRIEF.md
# Look-Ahead Mesh Route Stage with Downstream Wakeup

This unit is the route-computation stage of a five-port router in a two-dimensional mesh. It uses X-then-Y dimension-order routing, computed one hop ahead. Every head flit arrives with a small port field that was written by the previous router. The current router uses that field as-is to select its own crossbar output. In the same stage, it works out which output the following router will need and writes that code back into the head flit before the flit leaves. Body and tail flits follow the port latched from their head flit, as in wormhole switching.

The stage already knows the next router and its exit direction. It therefore pulses a wakeup line toward that neighbour, so a sleeping input channel there can switch its power back on before the head flit reaches it. The packet then spends two more router stages on the way, which leaves several cycles of margin to hide the wake delay. The router's own mesh coordinates come in as static input ports, so one netlist serves every tile.

The stage holds one register: a flit presented in one cycle appears at the outputs in the next cycle, together with its crossbar select and any wakeup.

Top module: `lookahead_route`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` is 0, `wake` is all zeros and `outPort` is 0.
- R2: A flit accepted with `inValid` high appears on `outFlit` with `outValid` high exactly one cycle later. Every bit other than the 3-bit port field `[2:0]` of a rewritten head is copied unchanged. With `inValid` low, `outValid` is low one cycle later.
- R3: The flit type is `inFlit[63:62]`: 01 is a head, 11 is a single-flit packet (head and tail), 00 is a body flit and 10 is a tail flit. For a head, `outPort` equals the incoming port field `[2:0]`. The codes are 0 local core, 1 X+ (x increasing), 2 X- (x decreasing), 3 Y+ (y increasing) and 4 Y- (y decreasing).
- R4: For a head going to a neighbour, the outgoing port field holds the dimension-order port of the next router. That router is at (myX±1, myY) or (myX, myY±1) according to the code. Destination x is at `[5:3]` and destination y is at `[8:6]`. The X dimension is resolved first: if the destination x is larger, the code is X+; if smaller, X-. Only when the x values are equal is Y+ or Y- chosen.
- R5: When the next router is the destination, the rewritten field is 0 (local core).
- R6: For a head going to a neighbour, `wake` has exactly one bit set, at the index equal to `outPort`, in the same cycle as the flit output. At every other time, `wake` has at most one bit set and is nonzero only together with `outValid`.
- R7: Body and tail flits leave with their port field unchanged and with `outPort` equal to the port of the most recent head. They raise no wakeup.
- R8: A head whose code is 0, whose code is 5 to 7, or whose direction points off the mesh edge leaves with its field unchanged and raises no wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| myX | input | 3 | X coordinate of this router |
| myY | input | 3 | Y coordinate of this router |
| inValid | input | 1 | A flit is presented on inFlit |
| inFlit | input | 64 | Incoming flit |
| outValid | output | 1 | outFlit holds a flit |
| outFlit | output | 64 | Flit with its head port field updated |
| outPort | output | 3 | Crossbar output select for this router |
| wake | output | 5 | One-cycle wakeup pulse per output direction, indexed by port code |

## Verification
A wrong next-router coordinate or a wrong X/Y comparison order shows up as a wrong port code in `outFlit[2:0]` in the cycle right after the head is accepted. The bench walks heads through all four directions and checks that cycle. A stale or corrupted held port shows up on `outPort` with the first body or tail flit after a head. A mis-decoded direction or a missed edge check shows up as a wake bit on the wrong line, or as a pulse where none is allowed, in that same output cycle.

// File: rtl/lookahead_route_pkg.sv
package lookahead_route_pkg;

  localparam int PORT_W    = 3;
  localparam int NUM_PORTS = 5;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XN    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YN    = 3'd4
  } port_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load output register with the incoming flit
    logic rewrite;   // replace head port field with next-hop code
    logic wakeEn;    // pulse wake toward the selected direction
  } strobe_t;

endpackage

// File: rtl/lookahead_route_ctrl.sv
module lookahead_route_ctrl
  import lookahead_route_pkg::*;
#(
  parameter int FLIT_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inType,
  input  logic [PORT_W-1:0] inCode,
  input  logic              dirLegal,
  output strobe_t           strobe,
  output logic [PORT_W-1:0] selPort
);

  logic              isHead;
  logic              codeKnown;
  logic              goesOut;
  logic [PORT_W-1:0] heldPort;

  // type bit 0 marks a head (01 head, 11 single-flit)
  assign isHead    = inValid && inType[0];
  assign codeKnown = (inCode <= PORT_W'(NUM_PORTS - 1));
  assign goesOut   = codeKnown && (inCode != PORT_LOCAL) && dirLegal;

  always_comb begin
    strobe.capture = inValid;
    strobe.rewrite = isHead && goesOut;
    strobe.wakeEn  = isHead && goesOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldPort <= '0;
    end else if (isHead) begin
      heldPort <= inCode;
    end
  end

  assign selPort = isHead ? inCode : heldPort;

  // R7
  body_follows_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isHead |=> heldPort == $past(inCode)));

  // R8
  no_rewrite_unknown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !codeKnown) |-> !strobe.rewrite);

endmodule

// File: rtl/lookahead_route_dp.sv
module lookahead_route_dp
  import lookahead_route_pkg::*;
#(
  parameter int FLIT_W = 64,
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW-1:0]     myX,
  input  logic [CW-1:0]     myY,
  input  logic [FLIT_W-1:0] inFlit,
  input  strobe_t           strobe,
  input  logic [PORT_W-1:0] selPort,
  output logic              dirLegal,
  output logic              outValid,
  output logic [FLIT_W-1:0] outFlit,
  output logic [PORT_W-1:0] outPort,
  output logic [NUM_PORTS-1:0] wake
);

  localparam int DX_LSB = PORT_W;
  localparam int DY_LSB = PORT_W + CW;
  localparam logic [CW-1:0] X_MAX = CW'(MESH_X - 1);
  localparam logic [CW-1:0] Y_MAX = CW'(MESH_Y - 1);

  logic [CW-1:0]       dstX, dstY;
  logic [CW-1:0]       nextX, nextY;
  logic [PORT_W-1:0]   inCode;
  logic [PORT_W-1:0]   nextCode;
  logic [FLIT_W-1:0]   flitNext;
  logic [NUM_PORTS-1:0] wakeNext;

  assign inCode = inFlit[PORT_W-1:0];
  assign dstX   = inFlit[DX_LSB +: CW];
  assign dstY   = inFlit[DY_LSB +: CW];

  // Edge check: direction must lead to an existing neighbour
  always_comb begin
    unique case (inCode)
      PORT_XP: dirLegal = (myX != X_MAX);
      PORT_XN: dirLegal = (myX != '0);
      PORT_YP: dirLegal = (myY != Y_MAX);
      PORT_YN: dirLegal = (myY != '0);
      default: dirLegal = 1'b1;
    endcase
  end

  // Coordinates of the router this flit enters next
  always_comb begin
    nextX = myX;
    nextY = myY;
    unique case (inCode)
      PORT_XP: nextX = myX + 1'b1;
      PORT_XN: nextX = myX - 1'b1;
      PORT_YP: nextY = myY + 1'b1;
      PORT_YN: nextY = myY - 1'b1;
      default: ;
    endcase
  end

  // Dimension-order decision made on behalf of the next router
  always_comb begin
    if (dstX > nextX)      nextCode = PORT_XP;
    else if (dstX < nextX) nextCode = PORT_XN;
    else if (dstY > nextY) nextCode = PORT_YP;
    else if (dstY < nextY) nextCode = PORT_YN;
    else                   nextCode = PORT_LOCAL;
  end

  always_comb begin
    flitNext = inFlit;
    if (strobe.rewrite) flitNext[PORT_W-1:0] = nextCode;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_wake
    assign wakeNext[p] = strobe.wakeEn && (selPort == PORT_W'(p));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outFlit  <= '0;
      outPort  <= '0;
      wake     <= '0;
    end else begin
      outValid <= strobe.capture;
      wake     <= wakeNext;
      if (strobe.capture) begin
        outFlit <= flitNext;
        outPort <= selPort;
      end
    end
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture |=> outValid));
  // R2
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture |=> !outValid));
  // R6
  wake_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wake));
  // R6
  wake_needs_flit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wake != '0) |-> outValid);
  // R6
  wake_matches_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wake != '0) |-> wake[outPort]);
  // R7
  body_no_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outFlit[FLIT_W-2]) |-> (wake == '0));
  // R8
  bad_code_no_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outPort >= PORT_W'(NUM_PORTS)) |-> (wake == '0));

endmodule

// File: rtl/lookahead_route.sv
module lookahead_route
  import lookahead_route_pkg::*;
#(
  parameter int FLIT_W = 64,
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW-1:0]     myX,
  input  logic [CW-1:0]     myY,
  input  logic              inValid,
  input  logic [FLIT_W-1:0] inFlit,
  output logic              outValid,
  output logic [FLIT_W-1:0] outFlit,
  output logic [2:0]        outPort,
  output logic [4:0]        wake
);

  strobe_t           strobe;
  logic [PORT_W-1:0] selPort;
  logic              dirLegal;

  lookahead_route_ctrl #(.FLIT_W(FLIT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inType   (inFlit[FLIT_W-1 -: 2]),
    .inCode   (inFlit[PORT_W-1:0]),
    .dirLegal (dirLegal),
    .strobe   (strobe),
    .selPort  (selPort)
  );

  lookahead_route_dp #(
    .FLIT_W(FLIT_W), .MESH_X(MESH_X), .MESH_Y(MESH_Y), .CW(CW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .myX      (myX),
    .myY      (myY),
    .inFlit   (inFlit),
    .strobe   (strobe),
    .selPort  (selPort),
    .dirLegal (dirLegal),
    .outValid (outValid),
    .outFlit  (outFlit),
    .outPort  (outPort),
    .wake     (wake)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && wake == '0 && outPort == '0));

endmodule

// File: tb/lookahead_route_test.sv
module lookahead_route_test;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    myX = 3'd3;
  logic [2:0]    myY = 3'd3;
  logic          inValid = 1'b0;
  logic [FW-1:0] inFlit = '0;
  logic          outValid;
  logic [FW-1:0] outFlit;
  logic [2:0]    outPort;
  logic [4:0]    wake;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lookahead_route uut (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY),
    .inValid(inValid), .inFlit(inFlit),
    .outValid(outValid), .outFlit(outFlit), .outPort(outPort), .wake(wake)
  );

  function automatic logic [FW-1:0] mkFlit(input logic [1:0] ty, input logic [2:0] code,
                                           input logic [2:0] dx, input logic [2:0] dy,
                                           input logic [52:0] pay);
    return {ty, pay, dy, dx, code};
  endfunction

  task automatic check(input string req, input string what, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Present one flit, then look at the outputs one cycle later
  task automatic sendOne(input string req, input logic [FW-1:0] f,
                         input logic [2:0] expField, input logic [2:0] expPort,
                         input logic [4:0] expWake);
    logic [FW-1:0] expFlit;
    inValid = 1'b1;
    inFlit  = f;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    expFlit = {f[FW-1:3], expField};
    check(req, "outValid", FW'(outValid), FW'(1));
    check(req, "outFlit", outFlit, expFlit);
    check(req, "outPort", FW'(outPort), FW'(expPort));
    check(req, "wake", FW'(wake), FW'(expWake));
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "outValid", FW'(outValid), FW'(0));
    check("R1", "wake", FW'(wake), FW'(0));
    check("R1", "outPort", FW'(outPort), FW'(0));
  endtask

  task automatic testDirections();
    // R4: X+ to (4,3), dst (6,1) -> still X+ there
    sendOne("R4", mkFlit(2'b01, 3'd1, 3'd6, 3'd1, 53'h1ABCD), 3'd1, 3'd1, 5'b00010);
    // R4: x resolved at (4,3), dst (4,5) -> Y+
    sendOne("R4", mkFlit(2'b01, 3'd1, 3'd4, 3'd5, 53'h0F0F0), 3'd3, 3'd1, 5'b00010);
    // R5: X- to (2,3) which is the destination
    sendOne("R5", mkFlit(2'b11, 3'd2, 3'd2, 3'd3, 53'h12345), 3'd0, 3'd2, 5'b00100);
    // R4: Y- to (3,2), dst (3,0) -> Y-
    sendOne("R4", mkFlit(2'b01, 3'd4, 3'd3, 3'd0, 53'h5555), 3'd4, 3'd4, 5'b10000);
    // R4: Y+ to (3,4), dst (0,7) -> X first, X-
    sendOne("R4", mkFlit(2'b01, 3'd3, 3'd0, 3'd7, 53'h7777), 3'd2, 3'd3, 5'b01000);
  endtask

  task automatic testWormhole();
    // R3/R6: head X- to (2,3), dst (0,6) -> X-
    sendOne("R3", mkFlit(2'b01, 3'd2, 3'd0, 3'd6, 53'hAAAA), 3'd2, 3'd2, 5'b00100);
    // R7: body with a stray field 5 keeps it, follows port 2, no wake
    sendOne("R7", mkFlit(2'b00, 3'd5, 3'd1, 3'd1, 53'hBBBB), 3'd5, 3'd2, 5'b00000);
    sendOne("R7", mkFlit(2'b10, 3'd1, 3'd7, 3'd7, 53'hCCCC), 3'd1, 3'd2, 5'b00000);
  endtask

  task automatic testIgnored();
    // R8: local code, invalid code, off-edge direction
    sendOne("R8", mkFlit(2'b01, 3'd0, 3'd3, 3'd3, 53'h1111), 3'd0, 3'd0, 5'b00000);
    sendOne("R8", mkFlit(2'b01, 3'd6, 3'd5, 3'd5, 53'h2222), 3'd6, 3'd6, 5'b00000);
    myX = 3'd7;
    sendOne("R8", mkFlit(2'b01, 3'd1, 3'd2, 3'd2, 53'h3333), 3'd1, 3'd1, 5'b00000);
    myX = 3'd3;
  endtask

  task automatic testBackToBack();
    // R2: consecutive heads each appear one cycle after their input
    inValid = 1'b1;
    inFlit  = mkFlit(2'b01, 3'd1, 3'd7, 3'd0, 53'h44);
    @(posedge clk);
    @(negedge clk);
    check("R2", "b2b first field", FW'(outFlit[2:0]), FW'(1));
    check("R2", "b2b first wake", FW'(wake), FW'(5'b00010));
    inFlit = mkFlit(2'b01, 3'd3, 3'd3, 3'd3, 53'h55);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check("R2", "b2b second field", FW'(outFlit[2:0]), FW'(4));
    check("R6", "b2b second wake", FW'(wake), FW'(5'b01000));
    @(posedge clk);
    @(negedge clk);
    check("R2", "idle outValid", FW'(outValid), FW'(0));
    check("R6", "idle wake", FW'(wake), FW'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "after reset outValid", FW'(outValid), FW'(0));
    testDirections();
    testWormhole();
    testIgnored();
    testBackToBack();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule